// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models the control and datapath of a synchronous SRAM with flow-through reads and late writes. Reads and writes can follow one another on every enabled clock with no idle cycle, including a write followed at once by a read. A command is taken at a rising edge when the active-low clock enable is low. The read word then appears combinationally during the cycle that follows that edge. A write takes its address, its kind and its lane selects at one edge and takes its data at the next enabled edge. That same edge may also carry the next command.

An on-chip burst counter steps through the two low address bits when advance/load is high. It follows either a wrapping add sequence or an XOR sequence. The common 18-bit data bus is split into a write-data input, a read-data output and a drive flag. Each 9-bit lane holds 8 data bits and 1 parity bit. The drive flag is cleared in three cases, whatever the asynchronous output enable is doing: while a write's data is on the bus, while the device is deselected, and in the first cycle of an access that follows a deselected cycle. The array depth is a parameter, and address bits above the array index are ignored.

Top module: `sramFlowTop`

## Requirements
- R1: An enabled edge with advLoadN low starts an access only when selAN is low, selB is high and selCN is low. wrEnN low starts a write and wrEnN high starts a read. Any other chip-select pattern on a load edge deselects the device.
- R2: While clkEnN is high, edges are ignored and all state holds, including a pending write data phase. That data phase completes with wrData sampled at the next edge where clkEnN is low.
- R3: In the cycle after a read is loaded, with outEnN low, dataOe is 1 and rdData equals the stored word for the access address. A read that is not driven shows rdData as 0.
- R4: A write stores wrData at the next enabled edge after the edge that took its address.
- R5: The byte selects are active low and are captured with the write address. byteSelN[0] gates bits [7:0] and bit 16. byteSelN[1] gates bits [15:8] and bit 17. Lanes that are not selected keep their old contents.
- R6: During a write's data cycle, dataOe is 0 even when outEnN is low.
- R7: After reset and after a deselecting edge, dataOe is 0. In the first cycle of an access loaded directly after a deselected cycle, dataOe is also 0.
- R8: outEnN high forces dataOe to 0 at once, with no clock edge. When it returns low, a pending read drives again in the same cycle.
- R9: An enabled edge with advLoadN high while an access is active advances the burst offset and keeps the access kind. With burstInterleave 0, address bits [1:0] are the base plus the offset, modulo 4. With burstInterleave 1, they are the base XOR the offset. Advancing while deselected does nothing.
- R10: Only the low log2(DEPTH) address bits select a word. Two addresses that differ only above those bits refer to the same word.
- R11: A read loaded on the data edge of a write to the same address returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| clkEnN | input | 1 | Active-low clock qualifier |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| advLoadN | input | 1 | Low loads a new command, high advances the burst |
| wrEnN | input | 1 | Low for a write, high for a read |
| byteSelN | input | 2 | Active-low lane write selects |
| burstInterleave | input | 1 | Burst order: 0 wrapping add, 1 XOR |
| addrIn | input | 18 | Word address |
| outEnN | input | 1 | Asynchronous active-low output enable |
| wrData | input | 18 | Write data with parity in bits 17:16 |
| rdData | output | 18 | Read data, 0 when not driven |
| dataOe | output | 1 | Bus drive flag |

## Verification
A wrong burst offset or a stale base address shows up in the very next read cycle, because rdData returns a neighbouring word. A lost pending write appears only later, when that address is read back; that read may come one cycle after the data edge. A drive flag left set in a write data cycle or in a re-entry cycle shows at dataOe within that same cycle. The bench therefore compares both outputs every cycle against a model built from the requirements. It mixes random traffic with stalls, deselects and both burst orders.

// File: rtl/sramFlowPkg.sv
package sramFlowPkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 wrStrobe;
    logic [NUM_LANES-1:0] laneEn;
    logic                 driveReq;
  } strobeT;
endpackage

// File: rtl/sramFlowCtrl.sv
module sramFlowCtrl
  import sramFlowPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 selAN,
  input  logic                 selB,
  input  logic                 selCN,
  input  logic                 advLoadN,
  input  logic                 wrEnN,
  input  logic [NUM_LANES-1:0] byteSelN,
  input  logic                 burstInterleave,
  input  logic [ADDR_W-1:0]    addrIn,
  output logic [IDX_W-1:0]     idxOut,
  output strobeT               strobe
);
  logic                 active;
  logic                 isWrite;
  logic                 firstCyc;
  logic [ADDR_W-1:0]    baseAddr;
  logic [1:0]           burstCnt;
  logic [NUM_LANES-1:0] laneSelN;
  logic                 edgeOn;
  logic                 selected;
  logic                 loadCmd;
  logic                 advCmd;
  logic [1:0]           lowBits;

  assign edgeOn   = !clkEnN;
  assign selected = !selAN && selB && !selCN;
  assign loadCmd  = edgeOn && !advLoadN;
  assign advCmd   = edgeOn && advLoadN && active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      isWrite  <= 1'b0;
      firstCyc <= 1'b0;
      baseAddr <= '0;
      burstCnt <= '0;
      laneSelN <= '1;
    end else if (loadCmd) begin
      if (selected) begin
        active   <= 1'b1;
        isWrite  <= !wrEnN;
        firstCyc <= !active;
        baseAddr <= addrIn;
        burstCnt <= '0;
        laneSelN <= byteSelN;
      end else begin
        active   <= 1'b0;
        firstCyc <= 1'b0;
      end
    end else if (advCmd) begin
      burstCnt <= burstCnt + 2'd1;
      firstCyc <= 1'b0;
    end
  end

  assign lowBits = burstInterleave ? (baseAddr[1:0] ^ burstCnt)
                                   : (baseAddr[1:0] + burstCnt);
  assign idxOut  = {baseAddr[IDX_W-1:2], lowBits};

  always_comb begin
    strobe.wrStrobe = edgeOn && active && isWrite;
    strobe.laneEn   = ~laneSelN;
    strobe.driveReq = active && !isWrite && !firstCyc;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(baseAddr) && $stable(active) && $stable(burstCnt))); // R2
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && selected) |=> (baseAddr == $past(addrIn) && burstCnt == 2'd0)); // R1
  AST_DESEL_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && !selected) |=> !strobe.driveReq); // R7
  AST_REENTRY_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && selected && !active) |=> !strobe.driveReq); // R7
  AST_WRITE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && selected && !wrEnN) |=> !strobe.driveReq); // R6
endmodule

// File: rtl/sramFlowData.sv
module sramFlowData
  import sramFlowPkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int IDX_W     = 10,
  parameter int LANE_BITS = 8,
  parameter int DATA_W    = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  strobeT            strobe,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dataOe
);
  localparam int PAR_BASE = NUM_LANES * LANE_BITS;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] mergedWord;

  assign curWord = memArr[idx];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    assign mergedWord[g*LANE_BITS +: LANE_BITS] = strobe.laneEn[g]
      ? wrData[g*LANE_BITS +: LANE_BITS] : curWord[g*LANE_BITS +: LANE_BITS];
    assign mergedWord[PAR_BASE+g] = strobe.laneEn[g]
      ? wrData[PAR_BASE+g] : curWord[PAR_BASE+g];

    AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStrobe && !strobe.laneEn[g]) |=>
      (memArr[$past(idx)][g*LANE_BITS +: LANE_BITS] ==
       $past(curWord[g*LANE_BITS +: LANE_BITS]))); // R5
  end

  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) memArr[idx] <= mergedWord;
  end

  assign dataOe = strobe.driveReq && !outEnN;
  assign rdData = dataOe ? curWord : '0;

  AST_WRITE_LAND: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && (&strobe.laneEn)) |=> (memArr[$past(idx)] == $past(wrData))); // R4
endmodule

// File: rtl/sramFlowTop.sv
module sramFlowTop
  import sramFlowPkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DEPTH     = 1024,
  parameter int LANE_BITS = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  clkEnN,
  input  logic                                  selAN,
  input  logic                                  selB,
  input  logic                                  selCN,
  input  logic                                  advLoadN,
  input  logic                                  wrEnN,
  input  logic [NUM_LANES-1:0]                  byteSelN,
  input  logic                                  burstInterleave,
  input  logic [ADDR_W-1:0]                     addrIn,
  input  logic                                  outEnN,
  input  logic [NUM_LANES*(LANE_BITS+1)-1:0]    wrData,
  output logic [NUM_LANES*(LANE_BITS+1)-1:0]    rdData,
  output logic                                  dataOe
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int DATA_W = NUM_LANES * (LANE_BITS + 1);

  logic [IDX_W-1:0] idx;
  strobeT           strobe;

  sramFlowCtrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .advLoadN(advLoadN), .wrEnN(wrEnN), .byteSelN(byteSelN),
    .burstInterleave(burstInterleave), .addrIn(addrIn),
    .idxOut(idx), .strobe(strobe)
  );

  sramFlowData #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LANE_BITS(LANE_BITS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .idx(idx), .strobe(strobe), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .dataOe(dataOe)
  );

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOe); // R8
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStrobe |-> !dataOe); // R6
endmodule

// File: tb/tb_sramFlowTop.sv
module tb_sramFlowTop;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEnN = 1'b0, selAN = 1'b1, selB = 1'b0, selCN = 1'b1;
  logic advLoadN = 1'b0, wrEnN = 1'b1, burstInterleave = 1'b0, outEnN = 1'b0;
  logic [1:0]  byteSelN = 2'b00;
  logic [17:0] addrIn = '0, wrData = '0;
  logic [17:0] rdData;
  logic        dataOe;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [17:0] mMem [1024];
  logic mActive = 0, mWrite = 0, mFirst = 0;
  logic [17:0] mBase = '0;
  logic [1:0]  mCnt = '0, mBe = '1;

  sramFlowTop dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selAN(selAN), .selB(selB),
    .selCN(selCN), .advLoadN(advLoadN), .wrEnN(wrEnN), .byteSelN(byteSelN),
    .burstInterleave(burstInterleave), .addrIn(addrIn), .outEnN(outEnN),
    .wrData(wrData), .rdData(rdData), .dataOe(dataOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] expIdx();
    logic [1:0] low;
    low = burstInterleave ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    return {mBase[9:2], low};
  endfunction

  task automatic compare(input string tag);
    logic        eOe;
    logic [17:0] eD;
    eOe = mActive && !mWrite && !mFirst && !outEnN;
    eD  = eOe ? mMem[expIdx()] : 18'h0;
    checks++;
    if (dataOe !== eOe) begin
      errors++;
      $display("FAIL %s dataOe actual %0b expected %0b", tag, dataOe, eOe);
    end
    checks++;
    if (rdData !== eD) begin
      errors++;
      $display("FAIL %s rdData actual %h expected %h", tag, rdData, eD);
    end
  endtask

  task automatic modelEdge();
    logic [9:0] i;
    if (clkEnN) return;
    if (mActive && mWrite) begin
      i = expIdx();
      for (int l = 0; l < 2; l++)
        if (!mBe[l]) begin
          mMem[i][l*8 +: 8] = wrData[l*8 +: 8];
          mMem[i][16+l]     = wrData[16+l];
        end
    end
    if (!advLoadN) begin
      if (!selAN && selB && !selCN) begin
        mFirst = !mActive; mActive = 1; mWrite = !wrEnN;
        mBe = byteSelN; mBase = addrIn; mCnt = 0;
      end else begin
        mActive = 0; mFirst = 0;
      end
    end else if (mActive) begin
      mCnt = mCnt + 2'd1; mFirst = 0;
    end
  endtask

  // selCode: 0 selected, 1 selAN high, 2 selB low, 3 selCN high
  task automatic cyc(input string tag, input logic cen, input logic adv,
                     input logic [1:0] selCode, input logic we, input logic [1:0] bs,
                     input logic [17:0] a, input logic [17:0] d, input logic oe);
    clkEnN = cen; advLoadN = adv; wrEnN = we; byteSelN = bs;
    addrIn = a; wrData = d; outEnN = oe;
    selAN = (selCode == 2'd1); selB = (selCode != 2'd2); selCN = (selCode == 2'd3);
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    modelEdge();
    #1;
  endtask

  task automatic probeOe();
    outEnN = 1'b1; #1; compare("R8 oe high");
    outEnN = 1'b0; #1; compare("R8 oe low");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 1024; k++) mMem[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dataOe !== 1'b0) begin
      errors++; $display("FAIL R7 reset dataOe actual %0b expected 0", dataOe);
    end
    rstN = 1'b1;
    #1;
    // deselect variants and a re-entry read (R1, R7)
    cyc("R1 desel a", 0, 0, 2'd1, 1, 2'b00, 18'd10, 0, 0);
    cyc("R1 desel b", 0, 0, 2'd2, 1, 2'b00, 18'd10, 0, 0);
    cyc("R1 desel c", 0, 0, 2'd3, 1, 2'b00, 18'd10, 0, 0);
    cyc("R7 reentry", 0, 0, 2'd0, 1, 2'b00, 18'd10, 0, 0);
    // fill words 0..63 (R4)
    for (int k = 0; k < 64; k++)
      cyc("R4 fill", 0, 0, 2'd0, 0, 2'b00, 18'(k), 18'(k * 4099 + 7), 0);
    // data edge of last write together with a read of the same word (R11)
    cyc("R11 wr3", 0, 0, 2'd0, 0, 2'b00, 18'd3, 18'd1000, 0);
    cyc("R6 wr data", 0, 0, 2'd0, 1, 2'b00, 18'd3, 18'h2ABCD, 0);
    cyc("R11 rd3", 0, 0, 2'd0, 1, 2'b00, 18'd3, 0, 0);
    probeOe();
    // lane masking (R5)
    cyc("R5 wr4", 0, 0, 2'd0, 0, 2'b10, 18'd4, 0, 0);
    cyc("R5 data", 0, 0, 2'd0, 1, 2'b00, 18'd4, 18'h3FFFF, 0);
    cyc("R5 rd4", 0, 0, 2'd0, 1, 2'b00, 18'd4, 0, 0);
    cyc("R5 wr4b", 0, 0, 2'd0, 0, 2'b01, 18'd4, 0, 0);
    cyc("R5 datab", 0, 0, 2'd0, 1, 2'b00, 18'd4, 18'h00000, 0);
    cyc("R5 rd4b", 0, 0, 2'd0, 1, 2'b00, 18'd4, 0, 0);
    // stall with pending write (R2)
    cyc("R2 wr5", 0, 0, 2'd0, 0, 2'b00, 18'd5, 0, 0);
    cyc("R2 stall", 1, 0, 2'd1, 1, 2'b11, 18'd9, 18'h11111, 0);
    cyc("R2 stall", 1, 1, 2'd0, 1, 2'b11, 18'd9, 18'h22222, 0);
    cyc("R2 data", 0, 0, 2'd0, 1, 2'b00, 18'd5, 18'h15A5A, 0);
    cyc("R2 rd5", 0, 0, 2'd0, 1, 2'b00, 18'd5, 0, 0);
    cyc("R2 stall rd", 1, 0, 2'd2, 0, 2'b00, 18'd7, 0, 0);
    // bursts (R9)
    cyc("R9 lin ld", 0, 0, 2'd0, 1, 2'b00, 18'd5, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R9 lin adv", 0, 1, 2'd3, 0, 2'b00, 18'd0, 0, 0);
    cyc("R9 desel", 0, 0, 2'd1, 1, 2'b00, 18'd0, 0, 0);
    cyc("R9 adv idle", 0, 1, 2'd0, 1, 2'b00, 18'd0, 0, 0);
    burstInterleave = 1'b1;
    cyc("R9 int ld", 0, 0, 2'd0, 1, 2'b00, 18'd5, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R9 int adv", 0, 1, 2'd0, 1, 2'b00, 18'd0, 0, 0);
    cyc("R9 int wr", 0, 0, 2'd0, 0, 2'b00, 18'd6, 0, 0);
    for (int k = 0; k < 3; k++) cyc("R9 int wadv", 0, 1, 2'd0, 1, 2'b00, 0, 18'(k + 300), 0);
    cyc("R9 wlast", 0, 0, 2'd0, 1, 2'b00, 18'd6, 18'd999, 0);
    for (int k = 0; k < 3; k++) cyc("R9 int rdadv", 0, 1, 2'd0, 1, 2'b00, 0, 0, 0);
    burstInterleave = 1'b0;
    // aliasing above index bits (R10)
    cyc("R10 wr", 0, 0, 2'd0, 0, 2'b00, 18'h0C007, 0, 0);
    cyc("R10 data", 0, 0, 2'd0, 1, 2'b00, 18'd7, 18'h0BEEF, 0);
    cyc("R10 rd", 0, 0, 2'd0, 1, 2'b00, 18'h30407 & 18'h3FC07, 0, 0);
    // random traffic (R3)
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] sc;
      if (k == 2000) begin
        cyc("R9 mode sw", 0, 0, 2'd1, 1, 2'b00, 0, 0, 0);
        burstInterleave = 1'b1;
      end
      sc = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
      cyc("R3 random", ($urandom % 6 == 0), ($urandom % 4 == 0), sc,
          1'($urandom), 2'($urandom), {8'($urandom), 4'b0000, 6'($urandom)},
          18'($urandom), ($urandom % 8 == 0));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule